// File: doc/BRIEF.md
# Context-Tagged Fully Associative Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses for 4 KB pages. It holds sixteen translations. Every lookup compares all of them at once. Each translation carries an 8-bit address-space context alongside its virtual page number, so translations that belong to different processes can sit in the buffer together. A process switch therefore needs no flush; the caller only presents the new context with each lookup.

A lookup returns its result combinationally, in the cycle it is presented. The result is one of three outcomes: a physical address, a miss, or a protection fault. The caller uses a miss or a fault to stop the access before it retires. Translations are installed through a fill port, which is driven by software or by a separate page walker. The fill port writes into the lowest free slot. When no slot is free, it replaces slots in rotating order. A flush command invalidates every translation of one context, or every translation when its global flag is set. The buffer also tracks whether each page has been written.

Top module: `tlb_ctx_top`

## Requirements
- R1: After reset no slot is valid, so every lookup reports a miss until a fill has been made.
- R2: A lookup with lk_valid high hits when a valid slot matches both the virtual page number (lk_vaddr[31:12]) and lk_ctx. In the same cycle, lk_paddr is the slot's frame number concatenated with lk_vaddr[11:0].
- R3: A slot matches only the context it was filled with. The same virtual page filled under two contexts resolves to each context's own frame, and a third context misses.
- R4: While lk_valid is high, exactly one of lk_hit, lk_miss and lk_fault is high. While lk_valid is low, all three are low. lk_paddr is zero whenever lk_hit is low.
- R5: Permission bits are perm[0] read, perm[1] write and perm[2] execute. Access kinds are encoded 00 read, 01 write, 10 execute and 11 reserved; the reserved kind is never permitted. A matching access whose permission bit is clear raises lk_fault instead of lk_hit.
- R6: lk_dirty shows the dirty bit of the matching slot, and is low when nothing matches. A permitted write that hits sets that bit from the next cycle on. A faulting write leaves it unchanged.
- R7: A fill writes the lowest-numbered invalid slot, setting it valid.
- R8: When all slots are valid, a fill replaces the slot named by a rotating pointer. The pointer is 0 after reset and advances by one, modulo 16, after each such replacement.
- R9: A flush with flush_all low invalidates every slot whose context equals flush_ctx and leaves every other slot untouched.
- R10: A flush with flush_all high invalidates every slot.
- R11: When more than one valid slot matches a request, the lowest-numbered slot supplies the result.
- R12: In a cycle with both a fill and a flush, the flush is applied first and the newly filled slot stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_ctx | input | 8 | Address-space context of the lookup |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No matching slot |
| lk_fault | output | 1 | Matching slot forbids this access kind |
| lk_dirty | output | 1 | Dirty bit of the matching slot |
| lk_paddr | output | 32 | Physical address, zero unless lk_hit |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ctx | input | 8 | Context of the new translation |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_perm | input | 3 | Permissions {exec, write, read} |
| fill_dirty | input | 1 | Initial dirty bit |
| flush_en | input | 1 | Invalidate translations this cycle |
| flush_ctx | input | 8 | Context to invalidate |
| flush_all | input | 1 | Invalidate every slot regardless of context |

## Verification
The dirty-bit property assumes that the lookup held across two cycles keeps the same address and context. It also assumes that no fill or flush happens between the write and the follow-up read. The bench's committed write is followed by a separate read of the same page, with the fill and flush ports idle. The flush-all property assumes that no fill happens in the same cycle. The bench never drives fill and flush together, except in the single scenario aimed at R12, where the flush is per-context. Inputs change only on the falling clock edge, so each combinational result is stable when the bench samples it.

// File: rtl/tlb_ctx_pkg.sv
package tlb_ctx_pkg;
    parameter int VA_W    = 32;
    parameter int OFF_W   = 12;
    parameter int VPN_W   = VA_W - OFF_W;
    parameter int PFN_W   = 20;
    parameter int PA_W    = PFN_W + OFF_W;
    parameter int CTX_W   = 8;
    parameter int PERM_W  = 3;
    parameter int N_SLOTS = 16;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [PERM_W-1:0] perm;
        logic [CTX_W-1:0]  ctx;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } slot_t;

    function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input acc_e kind);
        case (kind)
            ACC_READ:  return perm[0];
            ACC_WRITE: return perm[1];
            ACC_EXEC:  return perm[2];
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tlb_ctx_match.sv
module tlb_ctx_match
    import tlb_ctx_pkg::*;
#(
    parameter int N     = N_SLOTS,
    localparam int IDX_W = $clog2(N)
) (
    input  slot_t [N-1:0]    slots,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [CTX_W-1:0] req_ctx,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] hit_vec;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign hit_vec[g] = slots[g].valid && (slots[g].vpn == req_vpn)
                                && (slots[g].ctx == req_ctx);
        end
    endgenerate

    // Scan downward so that the lowest matching index is the last one kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_ctx_victim.sv
module tlb_ctx_victim
    import tlb_ctx_pkg::*;
#(
    parameter int N     = N_SLOTS,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid_vec,
    input  logic             fill_en,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             have_free;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    assign victim = have_free ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (fill_en && !have_free) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_ctx_top.sv
module tlb_ctx_top
    import tlb_ctx_pkg::*;
#(
    parameter int N     = N_SLOTS,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic [1:0]        lk_kind,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic              lk_dirty,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [CTX_W-1:0]  fill_ctx,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              fill_dirty,
    input  logic              flush_en,
    input  logic [CTX_W-1:0]  flush_ctx,
    input  logic              flush_all
);
    slot_t [N-1:0]    slot_q;
    logic [N-1:0]     valid_vec;
    logic             found;
    logic [IDX_W-1:0] found_idx;
    logic [IDX_W-1:0] victim_idx;
    slot_t            sel;
    acc_e             kind;
    logic             allowed;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_valid
            assign valid_vec[g] = slot_q[g].valid;
        end
    endgenerate

    tlb_ctx_match #(.N(N)) match_i (
        .slots   (slot_q),
        .req_vpn (lk_vaddr[VA_W-1:OFF_W]),
        .req_ctx (lk_ctx),
        .found   (found),
        .idx     (found_idx)
    );

    tlb_ctx_victim #(.N(N)) victim_i (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .fill_en   (fill_en),
        .victim    (victim_idx)
    );

    assign kind    = acc_e'(lk_kind);
    assign sel     = slot_q[found_idx];
    assign allowed = perm_allows(sel.perm, kind);

    always_comb begin
        lk_hit   = 1'b0;
        lk_miss  = 1'b0;
        lk_fault = 1'b0;
        lk_dirty = 1'b0;
        lk_paddr = '0;
        if (lk_valid) begin
            if (!found) begin
                lk_miss = 1'b1;
            end else begin
                lk_dirty = sel.dirty;
                if (allowed) begin
                    lk_hit   = 1'b1;
                    lk_paddr = {sel.pfn, lk_vaddr[OFF_W-1:0]};
                end else begin
                    lk_fault = 1'b1;
                end
            end
        end
    end

    // Later assignments win: flush, then dirty marking, then fill.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            if (flush_en) begin
                for (int i = 0; i < N; i++) begin
                    if (flush_all || (slot_q[i].ctx == flush_ctx)) begin
                        slot_q[i].valid <= 1'b0;
                    end
                end
            end
            if (lk_hit && (kind == ACC_WRITE)) begin
                slot_q[found_idx].dirty <= 1'b1;
            end
            if (fill_en) begin
                slot_q[victim_idx] <= '{valid: 1'b1, dirty: fill_dirty, perm: fill_perm,
                                        ctx: fill_ctx, vpn: fill_vpn, pfn: fill_pfn};
            end
        end
    end
endmodule

// File: rtl/tlb_ctx_chk.sv
module tlb_ctx_chk
    import tlb_ctx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [CTX_W-1:0]  lk_ctx,
    input logic [1:0]        lk_kind,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_fault,
    input logic              lk_dirty,
    input logic [PA_W-1:0]   lk_paddr,
    input logic              fill_en,
    input logic              flush_en,
    input logic              flush_all
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault)); // R4

    AST_NOHIT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> lk_paddr == '0); // R4

    AST_OFFSET_THRU: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]); // R2

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && lk_valid) |-> lk_miss); // R1

    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ($past(flush_en && flush_all && !fill_en) && lk_valid) |-> lk_miss); // R10

    AST_DIRTY_STICKS: assert property (@(posedge clk) disable iff (rst)
        ($past(lk_valid && lk_hit && lk_kind == 2'b01 && !fill_en && !flush_en)
         && lk_valid && !lk_miss && $stable(lk_vaddr) && $stable(lk_ctx)) |-> lk_dirty); // R6
endmodule

bind tlb_ctx_top tlb_ctx_chk chk_i (.*);

// File: tb/tlb_ctx_top_tb_top.sv
module tlb_ctx_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_ctx = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_ctx = '0;
    logic [19:0] fill_pfn = '0;
    logic [2:0]  fill_perm = '0;
    logic        fill_dirty = 1'b0;
    logic        flush_en = 1'b0;
    logic [7:0]  flush_ctx = '0;
    logic        flush_all = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic        r_hit, r_miss, r_fault, r_dirty;
    logic [31:0] r_pa;

    always #4 clk = ~clk;

    tlb_ctx_top dut_i (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] ctx, input logic [1:0] kind);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_ctx = ctx; lk_kind = kind;
        #2;
        r_hit = lk_hit; r_miss = lk_miss; r_fault = lk_fault;
        r_dirty = lk_dirty; r_pa = lk_paddr;
        lk_valid = 1'b0;
    endtask

    task automatic commit(input logic [31:0] va, input logic [7:0] ctx, input logic [1:0] kind);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_ctx = ctx; lk_kind = kind;
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] ctx, input logic [19:0] pfn,
                        input logic [2:0] perm);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_ctx = ctx; fill_pfn = pfn;
        fill_perm = perm; fill_dirty = 1'b0;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic flush(input logic [7:0] ctx, input logic all);
        @(negedge clk);
        flush_en = 1'b1; flush_ctx = ctx; flush_all = all;
        @(negedge clk);
        flush_en = 1'b0; flush_all = 1'b0;
    endtask

    task automatic t_reset();
        look(32'h1234_5678, 8'd1, 2'b00);
        chk("R1", "miss after reset", {31'd0, r_miss}, 32'd1);
        chk("R4", "paddr on miss", r_pa, 32'd0);
        @(negedge clk);
        #2;
        chk("R4", "idle outputs", {29'd0, lk_hit, lk_miss, lk_fault}, 32'd0);
    endtask

    task automatic t_basic();
        fill(20'h12345, 8'd3, 20'hABCDE, 3'b111);
        fill(20'h00001, 8'd3, 20'h00042, 3'b001);
        look(32'h1234_5678, 8'd3, 2'b00);
        chk("R2", "read hit paddr", r_pa, 32'hABCD_E678);
        chk("R2", "read hit flag", {31'd0, r_hit}, 32'd1);
        look(32'h1234_5FFC, 8'd3, 2'b10);
        chk("R2", "exec hit paddr", r_pa, 32'hABCD_EFFC);
        look(32'h0000_1FFF, 8'd3, 2'b00);
        chk("R2", "second slot paddr", r_pa, 32'h0004_2FFF);
    endtask

    task automatic t_context();
        fill(20'h12345, 8'd7, 20'h55555, 3'b111);
        look(32'h1234_5678, 8'd7, 2'b00);
        chk("R3", "ctx7 frame", r_pa, 32'h5555_5678);
        look(32'h1234_5678, 8'd3, 2'b00);
        chk("R3", "ctx3 frame", r_pa, 32'hABCD_E678);
        look(32'h1234_5678, 8'd9, 2'b00);
        chk("R3", "ctx9 misses", {31'd0, r_miss}, 32'd1);
        chk("R4", "miss paddr", r_pa, 32'd0);
    endtask

    task automatic t_perm();
        look(32'h0000_1010, 8'd3, 2'b01);
        chk("R5", "write fault", {29'd0, r_hit, r_miss, r_fault}, 32'b001);
        chk("R5", "fault paddr", r_pa, 32'd0);
        look(32'h0000_1010, 8'd3, 2'b10);
        chk("R5", "exec fault", {31'd0, r_fault}, 32'd1);
        look(32'h0000_1010, 8'd3, 2'b00);
        chk("R5", "read allowed", {31'd0, r_hit}, 32'd1);
        look(32'h1234_5000, 8'd3, 2'b11);
        chk("R5", "reserved kind faults", {31'd0, r_fault}, 32'd1);
    endtask

    task automatic t_dirty();
        look(32'h1234_5000, 8'd3, 2'b00);
        chk("R6", "clean at fill", {31'd0, r_dirty}, 32'd0);
        commit(32'h0000_1000, 8'd3, 2'b01);
        look(32'h0000_1000, 8'd3, 2'b00);
        chk("R6", "faulting write leaves clean", {31'd0, r_dirty}, 32'd0);
        commit(32'h1234_5004, 8'd3, 2'b01);
        look(32'h1234_5000, 8'd3, 2'b00);
        chk("R6", "write sets dirty", {31'd0, r_dirty}, 32'd1);
        look(32'h1234_5000, 8'd7, 2'b00);
        chk("R6", "other ctx still clean", {31'd0, r_dirty}, 32'd0);
    endtask

    task automatic t_flush_prio();
        // Slots now 0..2 used; these land in slots 3 and 4.
        fill(20'h0AAAA, 8'h20, 20'h11111, 3'b111);
        fill(20'h0BBBB, 8'h21, 20'h22222, 3'b111);
        flush(8'h20, 1'b0);
        look(32'h0AAA_A000, 8'h20, 2'b00);
        chk("R9", "flushed ctx misses", {31'd0, r_miss}, 32'd1);
        look(32'h1234_5678, 8'd3, 2'b00);
        chk("R9", "other ctx survives", r_pa, 32'hABCD_E678);
        look(32'h0BBB_B123, 8'h21, 2'b00);
        chk("R9", "ctx21 survives", r_pa, 32'h2222_2123);
        // Refill into freed slot 3: duplicate of slot 4 with a different frame.
        fill(20'h0BBBB, 8'h21, 20'h33333, 3'b111);
        look(32'h0BBB_B123, 8'h21, 2'b00);
        chk("R11", "lowest slot wins", r_pa, 32'h3333_3123);
        chk("R7", "fill used freed slot", {31'd0, r_hit}, 32'd1);
    endtask

    task automatic t_same_cycle();
        // Flush ctx 0x40 while filling an entry of ctx 0x40 (lands in slot 5).
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h04444; fill_ctx = 8'h40; fill_pfn = 20'h77777;
        fill_perm = 3'b111; flush_en = 1'b1; flush_ctx = 8'h40; flush_all = 1'b0;
        @(negedge clk);
        fill_en = 1'b0; flush_en = 1'b0;
        look(32'h0444_4000, 8'h40, 2'b00);
        chk("R12", "fill survives flush", r_pa, 32'h7777_7000);
    endtask

    task automatic t_replace();
        flush(8'd0, 1'b1);
        look(32'h1234_5678, 8'd3, 2'b00);
        chk("R10", "global flush", {31'd0, r_miss}, 32'd1);
        for (int i = 0; i < 16; i++) begin
            fill(20'h00100 + 20'(i), 8'd1, 20'h00200 + 20'(i), 3'b111);
        end
        look(32'h0010_F000, 8'd1, 2'b00);
        chk("R7", "slot 15 filled", r_pa, 32'h0020_F000);
        fill(20'h03000, 8'd1, 20'h03000, 3'b111);
        look(32'h0010_0000, 8'd1, 2'b00);
        chk("R8", "slot 0 replaced", {31'd0, r_miss}, 32'd1);
        look(32'h0300_0000, 8'd1, 2'b00);
        chk("R8", "new entry hits", r_pa, 32'h0300_0000);
        look(32'h0010_1000, 8'd1, 2'b00);
        chk("R8", "slot 1 kept", r_pa, 32'h0020_1000);
        fill(20'h03001, 8'd1, 20'h03001, 3'b111);
        look(32'h0010_1000, 8'd1, 2'b00);
        chk("R8", "slot 1 replaced next", {31'd0, r_miss}, 32'd1);
        look(32'h0010_2000, 8'd1, 2'b00);
        chk("R8", "slot 2 kept", r_pa, 32'h0020_2000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_context();
        t_perm();
        t_dirty();
        t_flush_prio();
        t_same_cycle();
        t_replace();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule